// File: doc/BRIEF.md
# Key-Unlocked Protected Register File

A bank of word-wide registers behind a plain single-cycle bus. Some registers are marked as guarded when the design is elaborated. A guarded register accepts a write only when the bus access just before it was a write of the key value to a dedicated lock word. All other registers take writes at any time. The unlock is single-shot. Any following bus access, read or write, to any address, uses it up, and the block locks again without software having to do anything.

Software unlocks the block by writing the key to the lock word. It then issues the guarded write as the very next access. If a guarded write arrives while the block is locked, the register keeps its contents and the block raises a one-cycle flag. Reading the lock word reports whether the block is unlocked. Like any other access, that read also uses up a pending unlock.

Top module: `regkey_top`

## Requirements
- R1: After reset every register reads 0, the block is locked, `rdData` is 0 and `wrDropped` is 0.
- R2: A write to an unguarded word is stored at the clock edge where `wrEn` is sampled, whatever the lock state.
- R3: A write of exactly 32'h0000_00AA to the lock word (index 31, byte offset 0x7C) unlocks the block. A read of the lock word returns 1 when the block is unlocked and 0 when it is locked, with all other bits 0.
- R4: A write of any other value to the lock word leaves the block locked and does not raise `wrDropped`.
- R5: A write to a guarded word that comes as the access right after a key write is stored.
- R6: A write to a guarded word while the block is locked leaves the word unchanged. `wrDropped` is then high for exactly the one cycle after that write's clock edge.
- R7: Any access (`wrEn` or `rdEn` high) other than a key write locks the block. This holds for unguarded writes and for reads, including a read of the lock word.
- R8: Cycles with neither `wrEn` nor `rdEn` high leave the lock state unchanged.
- R9: `rdData` presents the addressed word one clock after `rdEn` is sampled, and holds its value while `rdEn` is low. In the default map the guarded word indices are 0–7, 9, 15 and 31 (byte offsets 0x00–0x1C, 0x24, 0x3C, 0x7C).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wordAddr | input | IDX_W (5) | Word index (byte offset / 4) |
| wrData | input | DATA_W (32) | Write data |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| rdData | output | DATA_W (32) | Registered read data |
| wrDropped | output | 1 | One-cycle pulse for a blocked guarded write |

## Verification
The bench targets the single-shot window: a guarded write one access after the key, an unguarded write or a read placed between the key and the guarded write, and idle gaps in between. A design that keeps the unlock for longer would store the second write. A design that lets idle cycles re-lock the block would drop a legal write. Other cases are a near-miss key such as 0x1AA, which a design comparing only the low byte would accept, and a read of the lock word that must both report 1 and re-lock the block. The bench also checks that the drop flag lasts exactly one cycle and that read data holds between reads.

// File: rtl/regkey_pkg.sv
package regkey_pkg;

  // Strobes from the control path to the storage path.
  typedef struct packed {
    logic store;  // write the addressed word
    logic load;   // capture the addressed word onto rdData
  } ctrlStrobes_t;

endpackage

// File: rtl/regkey_ctrl.sv
module regkey_ctrl
  import regkey_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int DATA_W = 32,
  parameter int LOCK_IDX = 31,
  parameter logic [DATA_W-1:0] KEY = 32'h0000_00AA,
  parameter logic [NUM_REGS-1:0] PROT_MASK = 32'h8000_82FF,
  localparam int IDX_W = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [IDX_W-1:0]  wordAddr,
  input  logic [DATA_W-1:0] wrData,
  output ctrlStrobes_t      strobes,
  output logic              unlocked,
  output logic              wrDropped
);

  logic access;
  logic isLock;
  logic isGuarded;
  logic keyWrite;
  logic dropNow;
  logic unlockedNext;

  always_comb begin
    access    = wrEn | rdEn;
    isLock    = (wordAddr == IDX_W'(LOCK_IDX));
    isGuarded = PROT_MASK[wordAddr];
    keyWrite  = wrEn & isLock & (wrData == KEY);
    dropNow   = wrEn & ~isLock & isGuarded & ~unlocked;

    strobes.store = wrEn & ~isLock & (~isGuarded | unlocked);
    strobes.load  = rdEn;

    if (keyWrite)    unlockedNext = 1'b1;
    else if (access) unlockedNext = 1'b0;
    else             unlockedNext = unlocked;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      unlocked  <= 1'b0;
      wrDropped <= 1'b0;
    end else begin
      unlocked  <= unlockedNext;
      wrDropped <= dropNow;
    end
  end

  // The block unlocks only through a key write to the lock word.
  p_unlock_by_key_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(unlocked) |-> $past(wrEn && (wordAddr == IDX_W'(LOCK_IDX)) && (wrData == KEY)));

  // A bad key written to the lock word never leaves the block unlocked.
  p_bad_key_locks_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (wordAddr == IDX_W'(LOCK_IDX)) && (wrData != KEY)) |=> !unlocked);

  // Any access other than a key write uses up the unlock.
  p_single_shot_r7: assert property (@(posedge clk) disable iff (!rstN)
    (unlocked && (wrEn || rdEn) && !(wrEn && (wordAddr == IDX_W'(LOCK_IDX)) && (wrData == KEY)))
      |=> !unlocked);

  // Idle cycles keep the lock state.
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn || rdEn) |=> $stable(unlocked));

  // A drop pulse follows a write made while the block was locked.
  p_drop_when_locked_r6: assert property (@(posedge clk) disable iff (!rstN)
    wrDropped |-> $past(!unlocked && wrEn));

endmodule

// File: rtl/regkey_dp.sv
module regkey_dp
  import regkey_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int DATA_W = 32,
  parameter int LOCK_IDX = 31,
  parameter logic [NUM_REGS-1:0] PROT_MASK = 32'h8000_82FF,
  localparam int IDX_W = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic              unlocked,
  input  logic [IDX_W-1:0]  wordAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);

  logic [DATA_W-1:0] regQ [NUM_REGS];
  logic [DATA_W-1:0] rdMux;

  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_word
    if (gi == LOCK_IDX) begin : g_lock
      assign regQ[gi] = '0;
    end else begin : g_store
      always_ff @(posedge clk) begin
        if (!rstN)
          regQ[gi] <= '0;
        else if (strobes.store && (wordAddr == IDX_W'(gi)))
          regQ[gi] <= wrData;
      end
      if (PROT_MASK[gi]) begin : g_guard
        // A guarded word never changes while the block is locked.
        p_locked_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
          !unlocked |=> $stable(regQ[gi]));
      end
    end
  end

  always_comb begin
    if (wordAddr == IDX_W'(LOCK_IDX))
      rdMux = {{(DATA_W-1){1'b0}}, unlocked};
    else
      rdMux = regQ[wordAddr];
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      rdData <= '0;
    else if (strobes.load)
      rdData <= rdMux;
  end

  // Read data holds between reads.
  p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.load |=> $stable(rdData));

endmodule

// File: rtl/regkey_top.sv
module regkey_top
  import regkey_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int DATA_W = 32,
  parameter int LOCK_IDX = 31,
  parameter logic [DATA_W-1:0] KEY = 32'h0000_00AA,
  parameter logic [NUM_REGS-1:0] PROT_MASK = 32'h8000_82FF,
  localparam int IDX_W = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [IDX_W-1:0]  wordAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrEn,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic              wrDropped
);

  ctrlStrobes_t strobes;
  logic         unlocked;

  regkey_ctrl #(
    .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .LOCK_IDX(LOCK_IDX),
    .KEY(KEY), .PROT_MASK(PROT_MASK)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn),
    .wordAddr(wordAddr), .wrData(wrData),
    .strobes(strobes), .unlocked(unlocked), .wrDropped(wrDropped)
  );

  regkey_dp #(
    .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .LOCK_IDX(LOCK_IDX),
    .PROT_MASK(PROT_MASK)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .unlocked(unlocked),
    .wordAddr(wordAddr), .wrData(wrData), .rdData(rdData)
  );

endmodule

// File: tb/sim_regkey_top.sv
module sim_regkey_top;
  localparam int CLK_PERIOD = 10;
  localparam int LOCKW = 31;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  wordAddr = '0;
  logic [31:0] wrData = '0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [31:0] rdData;
  logic        wrDropped;

  int checks = 0;
  int errors = 0;

  logic [31:0] model [32];
  logic        expUnlocked = 1'b0;
  logic [31:0] expRd = '0;

  regkey_top u0 (
    .clk(clk), .rstN(rstN), .wordAddr(wordAddr), .wrData(wrData),
    .wrEn(wrEn), .rdEn(rdEn), .rdData(rdData), .wrDropped(wrDropped)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic guarded(input int idx);
    return (idx <= 7) || (idx == 9) || (idx == 15) || (idx == LOCKW);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // One bus access; outputs are checked just after the clock edge that samples it.
  task automatic access(input logic w, input logic r, input int idx,
                        input logic [31:0] d, input string tag);
    logic expDrop;
    logic [31:0] oldVal;
    oldVal = (idx == LOCKW) ? {31'b0, expUnlocked} : model[idx];
    expDrop = 1'b0;
    @(negedge clk);
    wrEn = w; rdEn = r; wordAddr = 5'(idx); wrData = d;
    @(posedge clk);
    #1;
    wrEn = 1'b0; rdEn = 1'b0;
    if (w && idx != LOCKW) begin
      if (!guarded(idx) || expUnlocked) model[idx] = d;
      else expDrop = 1'b1;
    end
    if (r) expRd = oldVal;
    if (w && idx == LOCKW && d == 32'hAA) expUnlocked = 1'b1;
    else if (w || r) expUnlocked = 1'b0;
    check({tag, " drop"}, {31'b0, wrDropped}, {31'b0, expDrop});
    if (r) check({tag, " rd"}, rdData, expRd);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      @(posedge clk);
      #1;
      check("R6 pulse width", {31'b0, wrDropped}, 32'h0);
      check("R9 hold", rdData, expRd);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1 reset state
    check("R1 rdData", rdData, 32'h0);
    check("R1 drop", {31'b0, wrDropped}, 32'h0);
    access(0, 1, 5'h0A, 0, "R1");
    access(0, 1, LOCKW, 0, "R1 R3");
    // R2 unguarded writes
    access(1, 0, 21, 32'h1234_5678, "R2");
    access(0, 1, 21, 0, "R2");
    access(1, 0, 10, 32'hCAFE_0001, "R2");
    access(0, 1, 10, 0, "R2");
    // R6 locked guarded write
    access(1, 0, 0, 32'hDEAD_BEEF, "R6");
    idle(1);
    access(0, 1, 0, 0, "R6");
    // R3 lock readback, R7 read consumes
    access(1, 0, LOCKW, 32'hAA, "R3");
    access(0, 1, LOCKW, 0, "R3");
    access(0, 1, LOCKW, 0, "R7");
    // R5 guarded write after key
    access(1, 0, LOCKW, 32'hAA, "R5");
    access(1, 0, 1, 32'h0BAD_F00D, "R5");
    access(0, 1, 1, 0, "R5");
    // R7 unguarded write consumes
    access(1, 0, LOCKW, 32'hAA, "R7");
    access(1, 0, 10, 32'h5555_AAAA, "R7");
    access(1, 0, 2, 32'h0000_0002, "R7");
    access(0, 1, 2, 0, "R7");
    // R7 read consumes
    access(1, 0, LOCKW, 32'hAA, "R7");
    access(0, 1, 21, 0, "R7");
    access(1, 0, 3, 32'h0000_0003, "R7");
    // R8 idle keeps unlock
    access(1, 0, LOCKW, 32'hAA, "R8");
    idle(5);
    access(1, 0, 4, 32'h4444_4444, "R8");
    access(0, 1, 4, 0, "R8");
    // R4 bad keys
    access(1, 0, LOCKW, 32'h55, "R4");
    access(0, 1, LOCKW, 0, "R4");
    access(1, 0, LOCKW, 32'h1AA, "R4");
    access(1, 0, 9, 32'h9999_9999, "R4");
    access(1, 0, LOCKW, 32'hAA, "R4");
    access(1, 0, LOCKW, 32'h00, "R4");
    access(1, 0, 15, 32'hFFFF_0000, "R4");
    access(0, 1, 15, 0, "R4");
    // R9 read data holds
    idle(3);
    // random mix
    void'($urandom(32'd20240611));
    for (int k = 0; k < 600; k++) begin
      int op;
      int idx;
      logic [31:0] d;
      op = int'($urandom_range(0, 5));
      idx = int'($urandom_range(0, 31));
      d = $urandom;
      case (op)
        0, 1: access(1, 0, idx, d, "R2 R5 R6");
        2: access(1, 0, LOCKW, 32'hAA, "R3");
        3: access(0, 1, idx, 0, "R9 R7");
        4: idle(1);
        default: access(1, 0, LOCKW, d & 32'h1FF, "R4");
      endcase
    end
    for (int i = 0; i < 31; i++) access(0, 1, i, 0, "R9 final");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule